// File: doc/BRIEF.md
# Gated Synchronous Serial Word Receiver (four channels)

This block receives science data from up to four sending units. Each sender drives its own link clock, a gate and a serial data line. The receiver brings all three signals into the local system clock domain and looks for rising edges of the link clock. While the gate is active it shifts the data bits, most significant bit first, into 24-bit words. Each finished word goes into that channel's first-in first-out buffer.

A processor drains the buffers through one shared read port. The port shows the oldest word of the selected channel, and a read strobe removes it. Each channel raises a level interrupt while its buffer is at least half full, so the processor can empty words in bursts rather than one per word. The buffer depth is a parameter; a flight configuration uses 8192 words per channel.

Sticky overflow and framing flags report lost words and gates that closed part-way through a word. Each flag has its own clear input. The link clocks run well below the system clock: 250 kHz and 2.5 MHz against a system clock of 16 MHz or more.

Top module: `gsr_rx_quad`

## Requirements
- R1: After reset every channel reports an empty buffer, and its half-full interrupt, overflow flag and framing flag are all low.
- R2: While a channel's gate is high, each rising edge of its link clock captures one data bit. The first bit captured becomes bit 23 of the word. After 24 bits the word is stored in the buffer.
- R3: `rd_data` shows the oldest stored word of the channel picked by `rd_sel`. A high `rd_en` removes that word at the clock edge. Words come out in the order they were stored, and `rd_empty` is high exactly when a channel holds no word.
- R4: `half_irq` of a channel is high while the channel holds at least DEPTH/2 words and low while it holds fewer.
- R5: A word that completes while the buffer holds DEPTH words is dropped and the stored words are kept. The channel's `ovf_flag` goes high and stays high until `ovf_clr` is pulsed. A new overflow in the same cycle as a clear wins.
- R6: If the gate falls after one to 23 bits of a word, those bits are discarded and `frm_flag` goes high until `frm_clr` is pulsed. The next word after that starts at bit 23 again.
- R7: The four channels work at the same time and each has its own link rate. A word on one channel never changes another channel's buffer or flags.
- R8: Link clock edges that occur while the gate is low store nothing.
- R9: `rd_en` on an empty channel has no effect. A word stored afterwards is read out unchanged and leaves the channel empty once it is read.
- R10: Each high and low phase of a link clock must last at least two system clock periods. Data and gate must be stable for that long around a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| lnk_clk | input | NCH | Link clock from each sender |
| lnk_gate | input | NCH | Gate from each sender, high while a word is framed |
| lnk_dat | input | NCH | Serial data from each sender |
| rd_sel | input | SEL_W | Channel shown on the read port |
| rd_en | input | 1 | Removes the word shown on `rd_data` |
| rd_data | output | 24 | Oldest word of the selected channel |
| rd_empty | output | NCH | Per-channel buffer empty |
| half_irq | output | NCH | Per-channel half-full interrupt, level |
| ovf_flag | output | NCH | Per-channel sticky overflow flag |
| ovf_clr | input | NCH | Per-channel overflow clear |
| frm_flag | output | NCH | Per-channel sticky framing-error flag |
| frm_clr | input | NCH | Per-channel framing clear |

## Verification
The hardest state to reach from the ports is a completed word arriving while the buffer is exactly full. That needs DEPTH serial words in a row with no reads. The bench builds the design with an eight-word buffer. It fills one channel word by word and checks the interrupt after every word and again before every read. It then sends one more word to reach the full-buffer drop. A framing error is forced by closing the gate after ten bits. All four channels are then driven at once from parallel threads, each with a different half period.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
    parameter int unsigned GSR_WORD_W = 24;
    localparam int unsigned GSR_CNT_W = $clog2(GSR_WORD_W);
    typedef logic [GSR_WORD_W-1:0] gsr_word_t;

    typedef struct packed {
        logic [1:0] clk_s;
        logic [1:0] gate_s;
        logic [1:0] dat_s;
        logic       clk_prev;
        logic       gate_prev;
    } gsr_sync_t;

    typedef struct packed {
        gsr_word_t            shreg;
        logic [GSR_CNT_W-1:0] cnt;
        logic                 push;
        gsr_word_t            word;
        logic                 frm;
    } gsr_asm_t;
endpackage

// File: rtl/gsr_sync.sv
module gsr_sync
    import gsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lnk_clk,
    input  logic lnk_gate,
    input  logic lnk_dat,
    output logic bit_stb,
    output logic bit_val,
    output logic gate_fall
);
    gsr_sync_t st_q, st_d;

    always_comb begin
        st_d           = st_q;
        st_d.clk_s     = {st_q.clk_s[0], lnk_clk};
        st_d.gate_s    = {st_q.gate_s[0], lnk_gate};
        st_d.dat_s     = {st_q.dat_s[0], lnk_dat};
        st_d.clk_prev  = st_q.clk_s[1];
        st_d.gate_prev = st_q.gate_s[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_stb   = st_q.clk_s[1] & ~st_q.clk_prev & st_q.gate_s[1];
    assign bit_val   = st_q.dat_s[1];
    assign gate_fall = ~st_q.gate_s[1] & st_q.gate_prev;
endmodule

// File: rtl/gsr_assembler.sv
module gsr_assembler
    import gsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_stb,
    input  logic      bit_val,
    input  logic      gate_fall,
    input  logic      frm_clr,
    output logic      push,
    output gsr_word_t word,
    output logic      frm_flag
);
    gsr_asm_t st_q, st_d;
    logic     frm_evt;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        frm_evt   = 1'b0;
        if (bit_stb) begin
            st_d.shreg = {st_q.shreg[GSR_WORD_W-2:0], bit_val};
            if (st_q.cnt == GSR_CNT_W'(GSR_WORD_W - 1)) begin
                st_d.cnt  = '0;
                st_d.push = 1'b1;
                st_d.word = {st_q.shreg[GSR_WORD_W-2:0], bit_val};
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (gate_fall) begin
            frm_evt  = (st_q.cnt != '0);
            st_d.cnt = '0;
        end
        st_d.frm = (st_q.frm & ~frm_clr) | frm_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push     = st_q.push;
    assign word     = st_q.word;
    assign frm_flag = st_q.frm;

    // A stored word always ends on a word boundary
    assert_word_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.push |-> st_q.cnt == '0);
    // A framing event never coincides with a stored word
    assert_frame_no_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.frm) |-> !st_q.push);
endmodule

// File: rtl/gsr_fifo.sv
module gsr_fifo
    import gsr_pkg::*;
#(
    parameter int unsigned AW = 9
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  gsr_word_t wdata,
    input  logic      pop,
    input  logic      ovf_clr,
    output gsr_word_t rdata,
    output logic      empty,
    output logic      half,
    output logic      ovf
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned HALF  = DEPTH / 2;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t  st_q, st_d;
    gsr_word_t mem [DEPTH];
    logic      do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != (AW+1)'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) st_d.wp = st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        st_d.ovf = (st_q.ovf & ~ovf_clr) | (push & ~do_push);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= wdata;
    end

    assign rdata = mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign half  = (st_q.cnt >= (AW+1)'(HALF));
    assign ovf   = st_q.ovf;

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= (AW+1)'(DEPTH));
    assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.cnt == (AW+1)'(DEPTH)) |=> ovf);
    assert_irq_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == (AW+1)'(HALF)) |=> !half);
    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/gsr_rx_quad.sv
module gsr_rx_quad
    import gsr_pkg::*;
#(
    parameter int unsigned NCH   = 4,
    parameter int unsigned AW    = 9,
    parameter int unsigned SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        lnk_clk,
    input  logic [NCH-1:0]        lnk_gate,
    input  logic [NCH-1:0]        lnk_dat,
    input  logic [SEL_W-1:0]      rd_sel,
    input  logic                  rd_en,
    output logic [GSR_WORD_W-1:0] rd_data,
    output logic [NCH-1:0]        rd_empty,
    output logic [NCH-1:0]        half_irq,
    output logic [NCH-1:0]        ovf_flag,
    input  logic [NCH-1:0]        ovf_clr,
    output logic [NCH-1:0]        frm_flag,
    input  logic [NCH-1:0]        frm_clr
);
    gsr_word_t rdata_a [NCH];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic      bit_stb, bit_val, gate_fall, push, pop;
        gsr_word_t word;

        assign pop = rd_en && (rd_sel == SEL_W'(ch));

        gsr_sync u_sync (
            .clk(clk), .rst_n(rst_n),
            .lnk_clk(lnk_clk[ch]), .lnk_gate(lnk_gate[ch]), .lnk_dat(lnk_dat[ch]),
            .bit_stb(bit_stb), .bit_val(bit_val), .gate_fall(gate_fall)
        );
        gsr_assembler u_asm (
            .clk(clk), .rst_n(rst_n),
            .bit_stb(bit_stb), .bit_val(bit_val), .gate_fall(gate_fall),
            .frm_clr(frm_clr[ch]), .push(push), .word(word), .frm_flag(frm_flag[ch])
        );
        gsr_fifo #(.AW(AW)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(push), .wdata(word), .pop(pop), .ovf_clr(ovf_clr[ch]),
            .rdata(rdata_a[ch]), .empty(rd_empty[ch]), .half(half_irq[ch]), .ovf(ovf_flag[ch])
        );
    end

    assign rd_data = rdata_a[rd_sel];
endmodule

// File: tb/gsr_rx_quad_tb_top.sv
`timescale 1ns/1ps
module gsr_rx_quad_tb_top;
    localparam int NCH = 4;
    localparam int AW  = 3;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] lclk = '0, lgate = '0, ldat = '0;
    logic [1:0] rd_sel = '0;
    logic rd_en = 1'b0;
    logic [23:0] rd_data;
    logic [NCH-1:0] rd_empty, half_irq, ovf_flag, frm_flag;
    logic [NCH-1:0] ovf_clr = '0, frm_clr = '0;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    gsr_rx_quad #(.NCH(NCH), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .lnk_clk(lclk), .lnk_gate(lgate), .lnk_dat(ldat),
        .rd_sel(rd_sel), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
        .half_irq(half_irq), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
        .frm_flag(frm_flag), .frm_clr(frm_clr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] pat(input int k);
        return 24'h5A3C81 ^ (24'(k) * 24'h0137F1);
    endfunction

    task automatic send_bits(input int ch, input logic [23:0] w, input int nbits, input int hp);
        lgate[ch] = 1'b1;
        repeat (hp) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            ldat[ch] = w[23-i];
            repeat (hp) @(negedge clk);
            lclk[ch] = 1'b1;
            repeat (hp) @(negedge clk);
            lclk[ch] = 1'b0;
        end
        repeat (hp) @(negedge clk);
        lgate[ch] = 1'b0;
        repeat (hp + 6) @(negedge clk);
    endtask

    task automatic pop_chk(input int ch, input logic [23:0] exp, input string req);
        @(negedge clk);
        rd_sel = 2'(ch);
        #1;
        chk(rd_data == exp && !rd_empty[ch], req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input bit is_ovf, input int ch);
        @(negedge clk);
        if (is_ovf) ovf_clr[ch] = 1'b1; else frm_clr[ch] = 1'b1;
        @(negedge clk);
        ovf_clr = '0;
        frm_clr = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_empty == '1, "R1 empty", 32'(rd_empty), 32'hF);
        chk(half_irq == '0 && ovf_flag == '0 && frm_flag == '0, "R1 flags",
            {half_irq, ovf_flag, frm_flag}, 0);

        // R2 MSB-first assembly, several patterns
        begin
            logic [23:0] ws [4];
            ws[0] = 24'hFFFFFF; ws[1] = 24'h000000; ws[2] = 24'h800001; ws[3] = 24'hA5C3E7;
            for (int k = 0; k < 4; k++) send_bits(0, ws[k], 24, 3);
            for (int k = 0; k < 4; k++) pop_chk(0, ws[k], "R2 word");
            chk(rd_empty[0], "R3 empty after drain", 32'(rd_empty[0]), 1);
        end

        // R3 R4 R5 fill, half-full, overflow
        for (int k = 0; k <= DEPTH; k++) begin
            send_bits(1, pat(k), 24, 2);
            if (k < DEPTH) begin
                chk(half_irq[1] == (k + 1 >= DEPTH / 2), "R4 irq on fill", 32'(half_irq[1]),
                    32'(k + 1 >= DEPTH / 2));
                chk(!ovf_flag[1], "R5 no early ovf", 32'(ovf_flag[1]), 0);
            end
        end
        chk(ovf_flag[1], "R5 ovf set", 32'(ovf_flag[1]), 1);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            chk(half_irq[1] == (DEPTH - k >= DEPTH / 2), "R4 irq on drain", 32'(half_irq[1]),
                32'(DEPTH - k >= DEPTH / 2));
            pop_chk(1, pat(k), "R3 R5 order kept");
        end
        chk(rd_empty[1] && !half_irq[1], "R5 dropped word absent", {rd_empty[1], half_irq[1]}, 2);
        chk(ovf_flag[1], "R5 ovf sticky", 32'(ovf_flag[1]), 1);
        pulse(1'b1, 1);
        chk(!ovf_flag[1], "R5 ovf cleared", 32'(ovf_flag[1]), 0);

        // R6 framing error
        send_bits(2, 24'hDEADBE, 10, 3);
        chk(frm_flag[2], "R6 frm set", 32'(frm_flag[2]), 1);
        chk(rd_empty[2], "R6 partial discarded", 32'(rd_empty[2]), 1);
        send_bits(2, 24'h13579B, 24, 3);
        pop_chk(2, 24'h13579B, "R6 next word aligned");
        chk(frm_flag[2], "R6 frm sticky", 32'(frm_flag[2]), 1);
        pulse(1'b0, 2);
        chk(!frm_flag[2], "R6 frm cleared", 32'(frm_flag[2]), 0);

        // R8 clock edges with gate low
        for (int i = 0; i < 30; i++) begin
            ldat[3] = i[0];
            repeat (3) @(negedge clk);
            lclk[3] = 1'b1;
            repeat (3) @(negedge clk);
            lclk[3] = 1'b0;
        end
        repeat (8) @(negedge clk);
        chk(rd_empty[3] && !frm_flag[3], "R8 ungated edges ignored", {rd_empty[3], frm_flag[3]}, 2);

        // R9 read on empty
        @(negedge clk);
        rd_sel = 2'd3;
        rd_en = 1'b1;
        repeat (2) @(negedge clk);
        rd_en = 1'b0;
        chk(rd_empty[3], "R9 still empty", 32'(rd_empty[3]), 1);
        send_bits(3, 24'h2468AC, 24, 3);
        pop_chk(3, 24'h2468AC, "R9 word intact");
        chk(rd_empty[3], "R9 empty after one read", 32'(rd_empty[3]), 1);

        // R7 R10 all channels at once, different rates
        fork
            send_bits(0, pat(20), 24, 2);
            send_bits(1, pat(21), 24, 3);
            send_bits(2, pat(22), 24, 5);
            send_bits(3, pat(23), 24, 7);
        join
        for (int c = 0; c < NCH; c++) pop_chk(c, pat(20 + c), "R7 channel word");
        chk(rd_empty == '1 && ovf_flag == '0 && frm_flag == '0, "R7 no cross effect",
            {rd_empty, ovf_flag, frm_flag}, 32'hF00);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule